// File: doc/BRIEF.md
# Token-Indexed In-Flight Instruction Tracker

This block keeps the state of every instruction that a timing controller has in flight inside a functional model. Before anything else happens to an instruction, the controller asks for a token. The token is a slot index taken from a first-in first-out free list. From then on the token names that instruction in every request, and it indexes every table inside the block: the phase table, the speculative store entries and the age matrix.

Each token moves through a fixed sequence of phases. Any request that arrives in the wrong phase is refused with an error response and changes nothing. A memory-type instruction may carry out one memory step (load or store) after execute. A store is held per token as speculative data. Younger loads to the same address see it at once. Backing memory receives it only when the token is globally committed, and it is dropped if the token is aborted. Requests use a valid/ready handshake. At most one request is taken per cycle, and each taken request gets its response on the next cycle.

Top module: `tt_token_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid`, `err_pulse` and `mem_wr_en` are low. From the first cycle after reset, `req_ready` is high. After reset every token is free and the free list holds tokens 0 to N-1 in ascending order.
- R2: An allocate request (op 0) that finds the free list non-empty returns status OK (code 0) and the token at the head of the list. A token freed later joins the tail of the list.
- R3: An allocate request that finds the free list empty returns status STALL (code 2) and changes no state.
- R4: Ops are fetch (1), decode (2), execute (3), load (4), store (5), local commit (6), global commit (7) and abort (8). Each is accepted only from its prior phase: fetch after allocate, decode after fetch, execute after decode. Any other case returns status ERR (code 1) with `rsp_data` zero, pulses `err_pulse` for one cycle and leaves the state unchanged. A fetch returns `mem_rd_data` read at `req_addr`.
- R5: Load and store are accepted only after execute, and only one of them per token. Local commit is accepted after execute or after the memory step.
- R6: A load returns the store data of the youngest live token that was allocated before it and holds a valid store to the same address. When no such token exists, the load returns `mem_rd_data`.
- R7: Stores of tokens allocated after the loading token are never forwarded to it.
- R8: Global commit is accepted only after local commit. If the token holds a store, `mem_wr_en` is high for exactly one cycle, together with the response, carrying the stored address and data. The token then becomes free.
- R9: Abort is accepted for any token that is not free. It frees the token and discards its store, so no write ever occurs and later loads do not see the data.
- R10: A request taken in cycle t gets `rsp_valid` high in cycle t+1 only, with `rsp_token` echoing the request's token (or the allocated token for an OK allocate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 4 | Operation code |
| req_token | input | TOKEN_W | Token the request refers to |
| req_addr | input | ADDR_W | Fetch, load or store address |
| req_data | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 OK, 1 ERR, 2 STALL |
| rsp_token | output | TOKEN_W | Token of the response |
| rsp_data | output | DATA_W | Fetched word or load data |
| err_pulse | output | 1 | One-cycle pulse on a refused request |
| mem_rd_addr | output | ADDR_W | Backing memory read address |
| mem_rd_data | input | DATA_W | Backing memory read data, same cycle |
| mem_wr_en | output | 1 | Backing memory write strobe |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |

## Verification
The bench builds the block with its defaults: sixteen tokens and 32-bit addresses and data. At that size a burst of allocations drains the free list within a few requests, so the stall path and the FIFO reuse order are reached early and often. Store and load addresses come from a pool of four values. Several live tokens therefore regularly hold stores to one address, which exercises the youngest-older selection and the exclusion of younger stores under random interleaving of phases, aborts and commits.

// File: rtl/tt_pkg.sv
// Shared encodings for the token tracker: request ops, response status
// and per-token phase codes. Assumes a 4-bit op field on the request.
package tt_pkg;

    typedef enum logic [3:0] {
        OP_ALLOC    = 4'd0,
        OP_FETCH    = 4'd1,
        OP_DECODE   = 4'd2,
        OP_EXECUTE  = 4'd3,
        OP_LOAD     = 4'd4,
        OP_STORE    = 4'd5,
        OP_LCOMMIT  = 4'd6,
        OP_GCOMMIT  = 4'd7,
        OP_ABORT    = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_ERR   = 2'd1,
        ST_STALL = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        PH_FREE       = 3'd0,
        PH_ALLOC      = 3'd1,
        PH_FETCHED    = 3'd2,
        PH_DECODED    = 3'd3,
        PH_EXECUTED   = 3'd4,
        PH_MEMDONE    = 3'd5,
        PH_LCOMMITTED = 3'd6
    } phase_e;

endpackage

// File: rtl/tt_free_list.sv
// Circular FIFO of free token IDs. After reset it holds 0..N-1 in
// ascending order. Assumes the caller never pops and pushes in the same
// cycle for the same token; overflow and underflow requests are ignored.
module tt_free_list #(
    parameter  int N  = 16,
    localparam int TW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [TW-1:0] push_tok,
    output logic [TW-1:0] head_tok,
    output logic          empty
);

    localparam logic [TW-1:0] LAST = TW'(N - 1);
    localparam logic [TW:0]   FULL = (TW + 1)'(N);

    logic [TW-1:0] slot [N];
    logic [TW-1:0] rd_ptr, wr_ptr;
    logic [TW:0]   count;
    logic          pop_ok, push_ok;

    assign empty    = (count == '0);
    assign head_tok = slot[rd_ptr];
    assign pop_ok   = pop && !empty;
    assign push_ok  = push && (count != FULL);

    // Pointer, occupancy and slot updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) slot[i] <= TW'(i);
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= FULL;
        end else begin
            if (pop_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok) begin
                slot[wr_ptr] <= push_tok;
                wr_ptr       <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            count <= count + (TW + 1)'(push_ok) - (TW + 1)'(pop_ok);
        end
    end

endmodule

// File: rtl/tt_age_matrix.sv
// Relative age of live tokens. older[i][j] is set when token j was live
// at the moment token i was allocated. Assumes allocate and free never
// target the same cycle (one request per cycle).
module tt_age_matrix #(
    parameter  int N  = 16,
    localparam int TW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_en,
    input  logic [TW-1:0]         alloc_tok,
    input  logic                  free_en,
    input  logic [TW-1:0]         free_tok,
    input  logic [N-1:0]          live,
    output logic [N-1:0][N-1:0]   older
);

    // Load the new token's row and clear its column on allocate or free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc_en && alloc_tok == TW'(i))
                        older[i][j] <= live[j];
                    else if ((alloc_en && alloc_tok == TW'(j)) ||
                             (free_en && free_tok == TW'(j)))
                        older[i][j] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/tt_spec_store.sv
// One speculative store entry per token, plus the load-forwarding search.
// A load matches entries of tokens older than the loader with the same
// address; the youngest match wins. Assumes older[][] is consistent for
// live tokens.
module tt_spec_store #(
    parameter  int N  = 16,
    parameter  int AW = 32,
    parameter  int DW = 32,
    localparam int TW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [TW-1:0]       wr_tok,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic                clr_en,
    input  logic [TW-1:0]       clr_tok,
    input  logic [TW-1:0]       ld_tok,
    input  logic [AW-1:0]       ld_addr,
    input  logic [N-1:0][N-1:0] older,
    output logic                hit,
    output logic [DW-1:0]       hit_data,
    input  logic [TW-1:0]       rd_tok,
    output logic                rd_valid,
    output logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);

    logic [N-1:0]  valid;
    logic [AW-1:0] addr [N];
    logic [DW-1:0] data [N];
    logic [N-1:0]  cand, sel;

    // Valid bits: set on store, cleared on commit or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else begin
            if (clr_en) valid[clr_tok] <= 1'b0;
            if (wr_en)  valid[wr_tok]  <= 1'b1;
        end
    end

    // Address and data capture for a store.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr[wr_tok] <= wr_addr;
            data[wr_tok] <= wr_data;
        end
    end

    // Per-entry match against the loader's address and age row.
    for (genvar g = 0; g < N; g++) begin : g_cand
        assign cand[g] = valid[g] && (addr[g] == ld_addr) && older[ld_tok][g];
    end

    // Keep only the candidate that every other candidate is older than.
    always_comb begin
        sel = cand;
        for (int j = 0; j < N; j++)
            for (int k = 0; k < N; k++)
                if (k != j && cand[k] && !older[j][k]) sel[j] = 1'b0;
    end

    // One-hot mux of the selected entry's data.
    always_comb begin
        hit_data = '0;
        for (int j = 0; j < N; j++)
            if (sel[j]) hit_data = hit_data | data[j];
    end

    assign hit      = |cand;
    assign rd_valid = valid[rd_tok];
    assign rd_addr  = addr[rd_tok];
    assign rd_data  = data[rd_tok];

endmodule

// File: rtl/tt_token_tracker.sv
// Top of the token tracker. Checks each request against the token's
// phase, updates the phase table, free list, age matrix and store
// entries, and registers a response for the next cycle. Assumes
// mem_rd_data answers mem_rd_addr in the same cycle.
module tt_token_tracker #(
    parameter  int NUM_TOKENS = 16,
    parameter  int ADDR_W     = 32,
    parameter  int DATA_W     = 32,
    localparam int TOKEN_W    = $clog2(NUM_TOKENS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [3:0]         req_op,
    input  logic [TOKEN_W-1:0] req_token,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_data,
    output logic               rsp_valid,
    output logic [1:0]         rsp_status,
    output logic [TOKEN_W-1:0] rsp_token,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               err_pulse,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               mem_wr_en,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [DATA_W-1:0]  mem_wr_data
);
    import tt_pkg::*;

    localparam int N = NUM_TOKENS;

    phase_e                  phase_q [N];
    logic [N-1:0]            live;
    logic                    ready_q, accept;
    op_e                     op;
    phase_e                  cur_ph, ph_new;
    logic                    ph_wr, ok, stall, err;
    logic [TOKEN_W-1:0]      ph_tok, rsp_tok_d, head_tok;
    logic [DATA_W-1:0]       data_d;
    logic                    fl_empty, fl_pop, fl_push;
    logic                    st_wr, st_clr, gc_wr;
    logic                    hit, rd_valid;
    logic [DATA_W-1:0]       hit_data, rd_data;
    logic [ADDR_W-1:0]       rd_addr;
    logic [N-1:0][N-1:0]     older;

    assign req_ready   = ready_q;
    assign accept      = req_valid && ready_q;
    assign op          = op_e'(req_op);
    assign cur_ph      = phase_q[req_token];
    assign mem_rd_addr = req_addr;

    for (genvar g = 0; g < N; g++) begin : g_live
        assign live[g] = (phase_q[g] != PH_FREE);
    end

    tt_free_list #(.N(N)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (fl_pop),
        .push     (fl_push),
        .push_tok (req_token),
        .head_tok (head_tok),
        .empty    (fl_empty)
    );

    tt_age_matrix #(.N(N)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (fl_pop),
        .alloc_tok (head_tok),
        .free_en   (fl_push),
        .free_tok  (req_token),
        .live      (live),
        .older     (older)
    );

    tt_spec_store #(.N(N), .AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_wr),
        .wr_tok   (req_token),
        .wr_addr  (req_addr),
        .wr_data  (req_data),
        .clr_en   (st_clr),
        .clr_tok  (req_token),
        .ld_tok   (req_token),
        .ld_addr  (req_addr),
        .older    (older),
        .hit      (hit),
        .hit_data (hit_data),
        .rd_tok   (req_token),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // Phase check and side effects of the accepted request.
    always_comb begin
        ok        = 1'b0;
        stall     = 1'b0;
        ph_wr     = 1'b0;
        ph_new    = PH_FREE;
        ph_tok    = req_token;
        rsp_tok_d = req_token;
        data_d    = '0;
        fl_pop    = 1'b0;
        fl_push   = 1'b0;
        st_wr     = 1'b0;
        st_clr    = 1'b0;
        gc_wr     = 1'b0;
        if (accept) begin
            case (op)
                OP_ALLOC: begin
                    if (fl_empty) begin
                        stall = 1'b1;
                    end else begin
                        ok        = 1'b1;
                        fl_pop    = 1'b1;
                        ph_wr     = 1'b1;
                        ph_new    = PH_ALLOC;
                        ph_tok    = head_tok;
                        rsp_tok_d = head_tok;
                    end
                end
                OP_FETCH: if (cur_ph == PH_ALLOC) begin
                    ok = 1'b1; ph_wr = 1'b1; ph_new = PH_FETCHED;
                    data_d = mem_rd_data;
                end
                OP_DECODE: if (cur_ph == PH_FETCHED) begin
                    ok = 1'b1; ph_wr = 1'b1; ph_new = PH_DECODED;
                end
                OP_EXECUTE: if (cur_ph == PH_DECODED) begin
                    ok = 1'b1; ph_wr = 1'b1; ph_new = PH_EXECUTED;
                end
                OP_LOAD: if (cur_ph == PH_EXECUTED) begin
                    ok = 1'b1; ph_wr = 1'b1; ph_new = PH_MEMDONE;
                    data_d = hit ? hit_data : mem_rd_data;
                end
                OP_STORE: if (cur_ph == PH_EXECUTED) begin
                    ok = 1'b1; ph_wr = 1'b1; ph_new = PH_MEMDONE;
                    st_wr = 1'b1;
                end
                OP_LCOMMIT: if (cur_ph == PH_EXECUTED || cur_ph == PH_MEMDONE) begin
                    ok = 1'b1; ph_wr = 1'b1; ph_new = PH_LCOMMITTED;
                end
                OP_GCOMMIT: if (cur_ph == PH_LCOMMITTED) begin
                    ok = 1'b1; ph_wr = 1'b1; ph_new = PH_FREE;
                    fl_push = 1'b1; st_clr = 1'b1; gc_wr = rd_valid;
                end
                OP_ABORT: if (cur_ph != PH_FREE) begin
                    ok = 1'b1; ph_wr = 1'b1; ph_new = PH_FREE;
                    fl_push = 1'b1; st_clr = 1'b1;
                end
                default: ;
            endcase
        end
        err = accept && !ok && !stall;
    end

    // Phase table update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) phase_q[i] <= PH_FREE;
        end else if (ph_wr) begin
            phase_q[ph_tok] <= ph_new;
        end
    end

    // Registered response, error pulse, write strobe and ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q     <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_status  <= ST_OK;
            rsp_token   <= '0;
            rsp_data    <= '0;
            err_pulse   <= 1'b0;
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            ready_q    <= 1'b1;
            rsp_valid  <= accept;
            rsp_status <= stall ? ST_STALL : (err ? ST_ERR : ST_OK);
            rsp_token  <= rsp_tok_d;
            rsp_data   <= data_d;
            err_pulse  <= err;
            mem_wr_en  <= gc_wr;
            if (gc_wr) begin
                mem_wr_addr <= rd_addr;
                mem_wr_data <= rd_data;
            end
        end
    end

endmodule

// File: rtl/tt_token_tracker_chk.sv
// Port-level protocol checks for the token tracker, bound to every
// instance. Assumes the encodings of tt_pkg.
module tt_token_tracker_chk #(
    parameter int TOKEN_W = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [3:0]        req_op,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [DATA_W-1:0] rsp_data,
    input logic              err_pulse,
    input logic              mem_wr_en
);
    import tt_pkg::*;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready)); // R10

    AST_ERR_IS_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (rsp_valid && rsp_status == 2'(ST_ERR) && !mem_wr_en)); // R4

    AST_STALL_ONLY_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'(ST_STALL)) |-> $past(req_op) == 4'(OP_ALLOC)); // R3

    AST_WRITE_ON_GCOMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (rsp_valid && rsp_status == 2'(ST_OK) && $past(req_op) == 4'(OP_GCOMMIT))); // R8

    AST_REFUSED_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'(ST_OK)) |-> rsp_data == '0); // R4

endmodule

bind tt_token_tracker tt_token_tracker_chk #(
    .TOKEN_W (TOKEN_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/tt_token_tracker_bench.sv
`timescale 1ns/1ps
module tt_token_tracker_bench;
    import tt_pkg::*;

    localparam int NT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [3:0]  req_token = '0;
    logic [31:0] req_addr = '0, req_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [3:0]  rsp_token;
    logic [31:0] rsp_data;
    logic        err_pulse;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_en;
    logic [31:0] mem_wr_addr, mem_wr_data;

    int vecs = 0, fails = 0, cyc = 0;
    bit done = 0;

    // Reference model state
    int          m_ph  [NT];
    bit          m_sv  [NT];
    logic [31:0] m_sa  [NT], m_sd [NT];
    int          m_seq [NT];
    int          m_fl  [$];
    int          seqctr = 0;

    always #2 clk = ~clk;

    tt_token_tracker #(.NUM_TOKENS(NT), .ADDR_W(32), .DATA_W(32)) u_tt_token_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_token(req_token), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_token(rsp_token),
        .rsp_data(rsp_data), .err_pulse(err_pulse), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data)
    );

    task automatic check(input bit good, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input int op, input int st);
        if (st == 2) return "R3";
        if (st == 1) return "R4";
        case (op)
            0: return "R2";
            4, 5: return "R6";
            6: return "R5";
            7: return "R8";
            8: return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic apply(input int op, input int tok, input logic [31:0] addr,
                         input logic [31:0] data, input string tag_in);
        logic [31:0] mrd = $urandom;
        int e_st = 1, e_tok = tok, best = -1, p = m_ph[tok];
        logic [31:0] e_data = '0, e_wa = '0, e_wd = '0;
        bit e_wr = 0;
        string tag;
        case (op)
            0: if (m_fl.size() == 0) e_st = 2;
               else begin
                   e_st = 0; e_tok = m_fl.pop_front();
                   m_ph[e_tok] = 1; m_seq[e_tok] = seqctr++;
               end
            1: if (p == 1) begin e_st = 0; e_data = mrd; m_ph[tok] = 2; end
            2: if (p == 2) begin e_st = 0; m_ph[tok] = 3; end
            3: if (p == 3) begin e_st = 0; m_ph[tok] = 4; end
            4: if (p == 4) begin
                   e_st = 0; m_ph[tok] = 5;
                   for (int j = 0; j < NT; j++)
                       if (j != tok && m_sv[j] && m_sa[j] == addr && m_ph[j] != 0 &&
                           m_seq[j] < m_seq[tok] && (best < 0 || m_seq[j] > m_seq[best]))
                           best = j;
                   e_data = (best >= 0) ? m_sd[best] : mrd;
               end
            5: if (p == 4) begin
                   e_st = 0; m_ph[tok] = 5; m_sv[tok] = 1; m_sa[tok] = addr; m_sd[tok] = data;
               end
            6: if (p == 4 || p == 5) begin e_st = 0; m_ph[tok] = 6; end
            7: if (p == 6) begin
                   e_st = 0; e_wr = m_sv[tok]; e_wa = m_sa[tok]; e_wd = m_sd[tok];
                   m_ph[tok] = 0; m_sv[tok] = 0; m_fl.push_back(tok);
               end
            8: if (p != 0) begin
                   e_st = 0; m_ph[tok] = 0; m_sv[tok] = 0; m_fl.push_back(tok);
               end
            default: ;
        endcase
        tag = (tag_in != "") ? tag_in : op_tag(op, e_st);
        @(negedge clk);
        req_valid = 1'b1; req_op = op[3:0]; req_token = tok[3:0];
        req_addr = addr; req_data = data; mem_rd_data = mrd;
        @(posedge clk); #1;
        check(rsp_valid && rsp_status == e_st[1:0], tag, "status",
              {rsp_valid, 2'b0, rsp_status}, {1'b1, 2'b0, e_st[1:0]});
        check(rsp_token == e_tok[3:0], tag, "token", rsp_token, e_tok);
        check(rsp_data == e_data, tag, "data", rsp_data, e_data);
        check(err_pulse == (e_st == 1), "R4", "err_pulse", err_pulse, e_st == 1);
        check(mem_wr_en == e_wr && (!e_wr || (mem_wr_addr == e_wa && mem_wr_data == e_wd)),
              (op == 8) ? "R9" : "R8", "write", {mem_wr_en, mem_wr_addr, mem_wr_data},
              {e_wr, e_wa, e_wd});
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        check(!rsp_valid && !mem_wr_en && !err_pulse, "R10", "idle after response",
              {rsp_valid, mem_wr_en, err_pulse}, 0);
    endtask

    function automatic int pick_tok();
        int r = $urandom % NT;
        if ($urandom % 5 != 0)
            for (int k = 0; k < NT; k++)
                if (m_ph[(r + k) % NT] != 0) return (r + k) % NT;
        return r;
    endfunction

    function automatic int next_op(input int t);
        if ($urandom % 20 == 0) return 8;
        case (m_ph[t])
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 3;
            4: begin
                int r = $urandom % 3;
                return (r == 0) ? 4 : (r == 1) ? 5 : 6;
            end
            5: return 6;
            default: return 7;
        endcase
    endfunction

    initial begin
        logic [31:0] X = 32'h0000_0100;
        void'($urandom(32'd4242));
        for (int i = 0; i < NT; i++) begin
            m_ph[i] = 0; m_sv[i] = 0; m_sa[i] = '0; m_sd[i] = '0; m_seq[i] = 0;
            m_fl.push_back(i);
        end
        repeat (4) @(posedge clk);
        #1;
        check(!rsp_valid && !mem_wr_en && !err_pulse, "R1", "outputs in reset",
              {rsp_valid, mem_wr_en, err_pulse}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(req_ready && !rsp_valid && !mem_wr_en, "R1", "after reset",
              {req_ready, rsp_valid, mem_wr_en}, 3'b100);

        // R1/R2: sixteen allocations come out in ascending order; R3: then stall
        for (int i = 0; i < NT; i++) apply(0, 0, 0, 0, "R1");
        apply(0, 5, 0, 0, "R3");
        // R9 abort, double abort refused, FIFO reuse at tail (R2)
        apply(8, 3, 0, 0, "R9");
        apply(8, 3, 0, 0, "R4");
        apply(0, 0, 0, 0, "R2");
        // phase order violations (R4)
        apply(2, 0, 0, 0, "R4");
        apply(7, 0, 0, 0, "R4");
        // R6: forwarding chain on address X
        foreach (m_ph[t]) if (t != 3 && t <= 9) begin
            apply(1, t, 32'h40 + t, 0, "R4");
            apply(2, t, 0, 0, "R4");
            apply(3, t, 0, 0, "R4");
        end
        apply(5, 0, X, 32'hAAAA_0000, "R6");
        apply(4, 1, X, 0, "R6");
        apply(5, 2, X, 32'hBBBB_0000, "R6");
        apply(4, 4, X, 0, "R6");
        apply(1, 3, 32'h80, 0, "R4");
        apply(2, 3, 0, 0, "R4");
        apply(3, 3, 0, 0, "R4");
        apply(5, 3, X, 32'hCCCC_0000, "R7");
        apply(4, 6, X, 0, "R7");
        apply(8, 2, 0, 0, "R9");
        apply(4, 7, X, 0, "R9");
        apply(6, 0, 0, 0, "R5");
        apply(7, 0, 0, 0, "R8");
        apply(6, 8, 0, 0, "R5");
        apply(7, 8, 0, 0, "R8");
        apply(4, 9, X, 0, "R6");
        apply(5, 9, X, 32'h1, "R5");

        // constrained random mix
        for (int n = 0; n < 2500; n++) begin
            int t = pick_tok();
            int op = ($urandom % 4 == 0) ? int'($urandom % 10) : next_op(t);
            logic [31:0] a = 32'h200 + 32'(($urandom % 4) * 4);
            apply(op, t, a, $urandom, "");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            vecs++; fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule